// File: doc/BRIEF.md
# Stereo Limiter Gain Controller

This block is the attenuating half of an automatic level control for a stereo sample stream. On every sample strobe it takes the magnitude of the left and the right sample, and if the louder of the two has reached the selected detection level it lowers a shared target gain index. The size of that reduction depends on how far the sample overshoots digital full scale. Each channel's output gain index then moves to the target. The move happens at that channel's next zero crossing, at a timeout, or on the same sample, depending on the mode and on the overshoot.

Samples are signed and wider than the 24-bit full-scale word, so that overshoot above full scale can be measured. The gain index outputs feed a separate multiplier stage. This block never raises a gain: the gain index only recovers through reset or through a separate recovery path.

Top module: `stlim_gain_ctl`

## Requirements
- R1: During and after a synchronous reset, both gain outputs equal GAIN_INIT (100 by default) and nothing is pending.
- R2: The detection level is picked by thr_sel: 0 selects 6290567, 1 selects 5232269, 2 selects 4204261 and 3 selects 3152749. A strobed sample triggers when the larger magnitude of the two channels is at or above the selected level.
- R3: With zc_bypass low and both magnitudes below 8388608, a trigger posts a new target (the old target minus 1) only when no channel is pending. A pending channel takes the target at the first later strobe on which its sample changes sign against its previous sample or equals zero.
- R4: tmo_sel chooses the timeout: 0 gives 1024 strobes, 1 gives 128, 2 gives 256 and 3 gives 512. Channels still pending take the target on that strobe counted from the posting strobe.
- R5: The band is 3 if the magnitude is at least 2^25, 2 if at least 2^24, and 1 if at least 2^23. In bands 1 to 3, both gains drop on that strobe by 2^min(band, step_sel), and anything pending is dropped.
- R6: With zc_bypass high, every triggering strobe lowers both gains at once by exactly 1, whatever the band or step_sel. A strobe that does not trigger moves any pending channel to the target.
- R7: The gain index saturates at 0 and never wraps.
- R8: While enable is low, the gains do not change, and the pending flags and the timeout count are cleared.
- R9: Without a strobe the gains hold, and the gains never increase except at reset.
- R10: The most negative sample code counts as magnitude 2^26-1, which falls in band 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Limiter enable |
| smp_valid | input | 1 | Sample strobe, one cycle per sample period |
| smp_left | input | SMP_W | Left sample, signed |
| smp_right | input | SMP_W | Right sample, signed |
| thr_sel | input | 2 | Detection level select |
| step_sel | input | 2 | Attenuation step select |
| tmo_sel | input | 2 | Zero-crossing timeout select |
| zc_bypass | input | 1 | 1: update every strobe, no zero-crossing wait |
| gain_left | output | GAIN_W | Left gain index, registered |
| gain_right | output | GAIN_W | Right gain index, registered |

## Verification
The properties assume that every detection level lies below full scale, which holds only if SMP_W is at least 24+3. Under that assumption, any sample in a full-scale band has also triggered, so both gains must be equal one cycle later. They also assume that reset is held across at least one clock edge and that the configuration inputs are steady while smp_valid is high. The stimulus changes thr_sel, step_sel, tmo_sel, zc_bypass and enable only between strobes, on the falling clock edge. Sample values are kept inside the 27-bit signed range, including the most negative code.

// File: rtl/stlim_pkg.sv
package stlim_pkg;
  localparam int FS_W   = 24;
  localparam int GAIN_W = 8;

  typedef enum logic [1:0] {
    BAND_THR  = 2'd0,
    BAND_FS   = 2'd1,
    BAND_FS6  = 2'd2,
    BAND_FS12 = 2'd3
  } band_e;

  // detection levels for a 24-bit full scale of 2^23
  function automatic logic [31:0] thr_level(input logic [1:0] code);
    case (code)
      2'd0:    return 32'd6290567;
      2'd1:    return 32'd5232269;
      2'd2:    return 32'd4204261;
      default: return 32'd3152749;
    endcase
  endfunction
endpackage

// File: rtl/stlim_level_det.sv
module stlim_level_det
  import stlim_pkg::*;
#(
  parameter int SMP_W = 27
) (
  input  logic signed [SMP_W-1:0] smp_l,
  input  logic signed [SMP_W-1:0] smp_r,
  input  logic [1:0]              thr_sel,
  output logic                    over,
  output band_e                   band
);
  localparam int MAG_W = SMP_W - 1;
  localparam logic [MAG_W-1:0] ONE   = MAG_W'(1);
  localparam logic [MAG_W-1:0] LV_FS = ONE << (FS_W - 1);
  localparam logic [MAG_W-1:0] LV_6  = ONE << FS_W;
  localparam logic [MAG_W-1:0] LV_12 = ONE << (FS_W + 1);

  function automatic logic [MAG_W-1:0] mag(input logic signed [SMP_W-1:0] x);
    logic signed [SMP_W-1:0] n;
    n = -x;
    if (!x[SMP_W-1])     return x[MAG_W-1:0];
    else if (n[SMP_W-1]) return '1;  // most negative code
    else                 return n[MAG_W-1:0];
  endfunction

  logic [MAG_W-1:0] mag_l, mag_r, peak, th;

  always_comb begin
    mag_l = mag(smp_l);
    mag_r = mag(smp_r);
    peak  = (mag_l > mag_r) ? mag_l : mag_r;
    th    = MAG_W'(thr_level(thr_sel));
    over  = (peak >= th);
    if (peak >= LV_12)     band = BAND_FS12;
    else if (peak >= LV_6) band = BAND_FS6;
    else if (peak >= LV_FS) band = BAND_FS;
    else                   band = BAND_THR;
  end
endmodule

// File: rtl/stlim_zc_det.sv
module stlim_zc_det #(
  parameter int SMP_W = 27,
  parameter int CH    = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      smp_valid,
  input  logic [CH-1:0][SMP_W-1:0]  smp,
  output logic [CH-1:0]             zc
);
  logic [CH-1:0] prev_neg_q;

  for (genvar c = 0; c < CH; c++) begin : g_ch
    assign zc[c] = (smp[c][SMP_W-1] != prev_neg_q[c]) || (smp[c] == '0);

    always_ff @(posedge clk) begin
      if (rst)            prev_neg_q[c] <= 1'b0;
      else if (smp_valid) prev_neg_q[c] <= smp[c][SMP_W-1];
    end
  end
endmodule

// File: rtl/stlim_commit.sv
module stlim_commit
  import stlim_pkg::*;
#(
  parameter int               CH        = 2,
  parameter int               G_W       = GAIN_W,
  parameter logic [G_W-1:0]   GAIN_INIT = G_W'(100),
  parameter int               TMO_BASE  = 128
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     enable,
  input  logic                     smp_valid,
  input  logic                     over,
  input  band_e                    band,
  input  logic [1:0]               step_sel,
  input  logic [1:0]               tmo_sel,
  input  logic                     zc_bypass,
  input  logic [CH-1:0]            zc,
  output logic [CH-1:0][G_W-1:0]   gain
);
  localparam int TMO_MAX = TMO_BASE * 8;
  localparam int CNT_W   = $clog2(TMO_MAX) + 1;

  logic [CH-1:0][G_W-1:0] gain_q;
  logic [G_W-1:0]         tgt_q;
  logic [CH-1:0]          pend_q;
  logic [CNT_W-1:0]       cnt_q;

  logic [CNT_W-1:0] tmo_lim;
  logic [1:0]       shamt;
  logic [G_W-1:0]   step_g, tgt_dec;
  logic             cut_now, flush, expire;
  logic [CH-1:0]    take, left_over;

  always_comb begin
    case (tmo_sel)
      2'd0:    tmo_lim = CNT_W'(TMO_BASE * 8);
      2'd1:    tmo_lim = CNT_W'(TMO_BASE);
      2'd2:    tmo_lim = CNT_W'(TMO_BASE * 2);
      default: tmo_lim = CNT_W'(TMO_BASE * 4);
    endcase
    shamt   = (band < step_sel) ? band : step_sel;
    step_g  = zc_bypass ? G_W'(1) : (G_W'(1) << shamt);
    tgt_dec = (tgt_q >= step_g) ? (tgt_q - step_g) : '0;
    cut_now = over && (zc_bypass || band != BAND_THR);
    flush   = zc_bypass && !over;
    expire  = (|pend_q) && ((cnt_q + 1'b1) == tmo_lim);
    take    = pend_q & (zc | {CH{expire}});
    left_over = pend_q & ~take;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q  <= GAIN_INIT;
      gain_q <= {CH{GAIN_INIT}};
      pend_q <= '0;
      cnt_q  <= '0;
    end else if (!enable) begin
      pend_q <= '0;
      cnt_q  <= '0;
    end else if (smp_valid) begin
      if (cut_now) begin
        tgt_q <= tgt_dec;
        for (int c = 0; c < CH; c++) gain_q[c] <= tgt_dec;
        pend_q <= '0;
        cnt_q  <= '0;
      end else if (flush) begin
        for (int c = 0; c < CH; c++) if (pend_q[c]) gain_q[c] <= tgt_q;
        pend_q <= '0;
        cnt_q  <= '0;
      end else if (over && pend_q == '0) begin
        tgt_q  <= tgt_dec;
        pend_q <= '1;
        cnt_q  <= '0;
      end else begin
        for (int c = 0; c < CH; c++) if (take[c]) gain_q[c] <= tgt_q;
        pend_q <= left_over;
        cnt_q  <= (|left_over) ? cnt_q + 1'b1 : '0;
      end
    end
  end

  assign gain = gain_q;

  for (genvar c = 0; c < CH; c++) begin : g_chk
    // R9: a gain never rises outside reset
    a_r9_no_rise: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> gain_q[c] <= $past(gain_q[c]));
    // R3: a channel never sits below the shared target
    a_r3_gain_above_target: assert property (@(posedge clk) disable iff (rst)
      gain_q[c] >= tgt_q);
  end

  a_r8_pend_clear: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (pend_q == '0) && (cnt_q == '0));
  a_r8_hold_disabled: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(gain_q));
  a_r9_hold_no_strobe: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> $stable(gain_q) && $stable(tgt_q));
  a_r6_bypass_equal: assert property (@(posedge clk) disable iff (rst)
    enable && smp_valid && zc_bypass |=> gain_q[0] == gain_q[CH-1]);
  a_r5_fast_equal: assert property (@(posedge clk) disable iff (rst)
    enable && smp_valid && band != BAND_THR |=> gain_q[0] == gain_q[CH-1]);
endmodule

// File: rtl/stlim_gain_ctl.sv
module stlim_gain_ctl
  import stlim_pkg::*;
#(
  parameter int                SMP_W     = 27,
  parameter int                G_W       = GAIN_W,
  parameter logic [G_W-1:0]    GAIN_INIT = G_W'(100),
  parameter int                TMO_BASE  = 128
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    enable,
  input  logic                    smp_valid,
  input  logic signed [SMP_W-1:0] smp_left,
  input  logic signed [SMP_W-1:0] smp_right,
  input  logic [1:0]              thr_sel,
  input  logic [1:0]              step_sel,
  input  logic [1:0]              tmo_sel,
  input  logic                    zc_bypass,
  output logic [G_W-1:0]          gain_left,
  output logic [G_W-1:0]          gain_right
);
  localparam int CH = 2;

  logic                   over;
  band_e                  band;
  logic [CH-1:0]          zc;
  logic [CH-1:0][G_W-1:0] gain;

  stlim_level_det #(.SMP_W(SMP_W)) u_level (
    .smp_l   (smp_left),
    .smp_r   (smp_right),
    .thr_sel (thr_sel),
    .over    (over),
    .band    (band)
  );

  stlim_zc_det #(.SMP_W(SMP_W), .CH(CH)) u_zc (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .smp       ({smp_right, smp_left}),
    .zc        (zc)
  );

  stlim_commit #(.CH(CH), .G_W(G_W), .GAIN_INIT(GAIN_INIT), .TMO_BASE(TMO_BASE)) u_commit (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .smp_valid (smp_valid),
    .over      (over),
    .band      (band),
    .step_sel  (step_sel),
    .tmo_sel   (tmo_sel),
    .zc_bypass (zc_bypass),
    .zc        (zc),
    .gain      (gain)
  );

  assign gain_left  = gain[0];
  assign gain_right = gain[1];
endmodule

// File: tb/stlim_gain_ctl_test.sv
module stlim_gain_ctl_test;
  localparam int SW = 27;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0, smp_valid = 1'b0, zc_bypass = 1'b0;
  logic signed [SW-1:0] smp_left = '0, smp_right = '0;
  logic [1:0] thr_sel = 2'd0, step_sel = 2'd3, tmo_sel = 2'd1;
  logic [7:0] gain_left, gain_right;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  stlim_gain_ctl uut (
    .clk(clk), .rst(rst), .enable(enable), .smp_valid(smp_valid),
    .smp_left(smp_left), .smp_right(smp_right), .thr_sel(thr_sel),
    .step_sel(step_sel), .tmo_sel(tmo_sel), .zc_bypass(zc_bypass),
    .gain_left(gain_left), .gain_right(gain_right)
  );

  typedef struct packed {
    logic signed [SW-1:0] l;
    logic signed [SW-1:0] r;
    logic [1:0] thr;
    logic [1:0] stp;
    logic [1:0] tmo;
    logic       byp;
    logic       en;
    logic [7:0] el;
    logic [7:0] er;
    logic [3:0] req;
  } vec_t;

  localparam vec_t TBL [23] = '{
    '{ 27'sd1000,      -27'sd1000,    2'd0, 2'd3, 2'd1, 1'b0, 1'b1, 8'd100, 8'd100, 4'd2 }, // R2 quiet
    '{ 27'sd7000000,   27'sd5,        2'd0, 2'd3, 2'd1, 1'b0, 1'b1, 8'd100, 8'd100, 4'd3 }, // R3 post
    '{ 27'sd7000000,   -27'sd5,       2'd0, 2'd3, 2'd1, 1'b0, 1'b1, 8'd100, 8'd99,  4'd3 }, // R3 right zc
    '{ -27'sd3,        -27'sd5,       2'd0, 2'd3, 2'd1, 1'b0, 1'b1, 8'd99,  8'd99,  4'd3 }, // R3 left zc
    '{ 27'sd8388608,   27'sd0,        2'd0, 2'd3, 2'd1, 1'b0, 1'b1, 8'd97,  8'd97,  4'd5 }, // R5 band 1
    '{ 27'sd16777216,  27'sd0,        2'd0, 2'd3, 2'd1, 1'b0, 1'b1, 8'd93,  8'd93,  4'd5 }, // R5 band 2
    '{ 27'sd33554432,  27'sd0,        2'd0, 2'd3, 2'd1, 1'b0, 1'b1, 8'd85,  8'd85,  4'd5 }, // R5 band 3
    '{ 27'sd33554432,  27'sd0,        2'd0, 2'd1, 2'd1, 1'b0, 1'b1, 8'd83,  8'd83,  4'd5 }, // R5 step cap
    '{ -27'sd33554432, 27'sd0,        2'd0, 2'd0, 2'd1, 1'b0, 1'b1, 8'd82,  8'd82,  4'd5 }, // R5 step 1
    '{ -27'sd20000000, 27'sd0,        2'd0, 2'd3, 2'd1, 1'b1, 1'b1, 8'd81,  8'd81,  4'd6 }, // R6 forced 1
    '{ 27'sd7000000,   27'sd0,        2'd0, 2'd3, 2'd1, 1'b1, 1'b1, 8'd80,  8'd80,  4'd6 }, // R6 below FS
    '{ 27'sd100,       27'sd0,        2'd0, 2'd3, 2'd1, 1'b1, 1'b1, 8'd80,  8'd80,  4'd6 }, // R6 quiet
    '{ 27'sd4000000,   27'sd4000000,  2'd3, 2'd3, 2'd1, 1'b0, 1'b1, 8'd80,  8'd80,  4'd2 }, // R2 level 3 post
    '{ 27'sd1000,      27'sd1000,     2'd3, 2'd3, 2'd1, 1'b0, 1'b1, 8'd80,  8'd80,  4'd3 }, // R3 no zc
    '{ -27'sd1000,     -27'sd1000,    2'd3, 2'd3, 2'd1, 1'b0, 1'b0, 8'd80,  8'd80,  4'd8 }, // R8 disabled
    '{ 27'sd1000,      27'sd1000,     2'd3, 2'd3, 2'd1, 1'b0, 1'b1, 8'd80,  8'd80,  4'd8 }, // R8 pend gone
    '{ 27'sd5300000,   27'sd1000,     2'd1, 2'd3, 2'd1, 1'b0, 1'b1, 8'd80,  8'd80,  4'd2 }, // R2 level 1 post
    '{ -27'sd5300000,  -27'sd1,       2'd1, 2'd3, 2'd1, 1'b0, 1'b1, 8'd78,  8'd78,  4'd3 }, // R3 both zc
    '{ -27'sd4100000,  27'sd0,        2'd2, 2'd3, 2'd1, 1'b0, 1'b1, 8'd78,  8'd78,  4'd2 }, // R2 under level 2
    '{ 27'sd6290566,   27'sd0,        2'd0, 2'd3, 2'd1, 1'b0, 1'b1, 8'd78,  8'd78,  4'd2 }, // R2 one under
    '{ 27'sd6290567,   27'sd0,        2'd0, 2'd3, 2'd1, 1'b0, 1'b1, 8'd78,  8'd78,  4'd2 }, // R2 exact post
    '{ 27'sd6290567,   27'sd0,        2'd0, 2'd3, 2'd1, 1'b0, 1'b1, 8'd78,  8'd77,  4'd3 }, // R3 right first
    '{ -27'sd1,        -27'sd1,       2'd0, 2'd3, 2'd1, 1'b0, 1'b1, 8'd77,  8'd77,  4'd3 }  // R3 left later
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic send(input logic signed [SW-1:0] l, input logic signed [SW-1:0] r);
    @(negedge clk);
    smp_left = l; smp_right = r; smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset value
    chk("R1 reset left", gain_left, 8'd100);
    chk("R1 reset right", gain_right, 8'd100);
    rst = 1'b0; enable = 1'b1;
    // R9: a loud sample without a strobe leaves gains alone
    smp_left = 27'sd33554432;
    repeat (5) @(negedge clk);
    chk("R9 no strobe left", gain_left, 8'd100);
    chk("R9 no strobe right", gain_right, 8'd100);

    foreach (TBL[i]) begin
      thr_sel = TBL[i].thr; step_sel = TBL[i].stp; tmo_sel = TBL[i].tmo;
      zc_bypass = TBL[i].byp; enable = TBL[i].en;
      send(TBL[i].l, TBL[i].r);
      chk($sformatf("R%0d vec %0d left", TBL[i].req, i), gain_left, TBL[i].el);
      chk($sformatf("R%0d vec %0d right", TBL[i].req, i), gain_right, TBL[i].er);
    end

    // R4: 128-strobe timeout
    thr_sel = 2'd0; step_sel = 2'd3; tmo_sel = 2'd1; zc_bypass = 1'b0; enable = 1'b1;
    send(27'sd7000000, 27'sd7000000);
    for (int k = 0; k < 127; k++) send(27'sd1000, 27'sd1000);
    chk("R4 tmo128 before", gain_left, 8'd77);
    send(27'sd1000, 27'sd1000);
    chk("R4 tmo128 left", gain_left, 8'd76);
    chk("R4 tmo128 right", gain_right, 8'd76);

    // R4: default code 0 gives 1024 strobes
    tmo_sel = 2'd0;
    send(-27'sd7000000, -27'sd7000000);
    for (int k = 0; k < 1023; k++) send(-27'sd1000, -27'sd1000);
    chk("R4 tmo1024 before", gain_right, 8'd76);
    send(-27'sd1000, -27'sd1000);
    chk("R4 tmo1024 left", gain_left, 8'd75);
    chk("R4 tmo1024 right", gain_right, 8'd75);

    // R1 again, then R10 and R7 from fresh state
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 re-reset", gain_left, 8'd100);
    tmo_sel = 2'd1; step_sel = 2'd3;
    send(27'h4000000, 27'sd0);
    chk("R10 most negative", gain_left, 8'd92);
    for (int k = 0; k < 11; k++) send(27'h4000000, 27'sd0);
    chk("R7 near floor", gain_left, 8'd4);
    send(27'h4000000, 27'sd0);
    chk("R7 saturate left", gain_left, 8'd0);
    send(27'h4000000, 27'sd0);
    chk("R7 stay zero", gain_right, 8'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule